// File: doc/BRIEF.md
# Strap-Selected Configuration Bank Loader

At power-up this block decides how two shared pins are used and which stored configuration bank initializes the configuration registers. It reads a mode strap and the two pins on the first clock after reset is released. With the strap high, the pins act as a two-bit hardware bank selector. With the strap low, or left floating so that the pad resolves it to 0, the pins belong to a two-wire serial host bus and bank 0 is used. The decision is held until the next reset.

Once the decision is made, the block copies the chosen bank out of an internal read-only bank store into the configuration register file. It issues one write strobe per clock, with ascending register addresses. When the last register has been written, a sticky done flag rises. The serial host bus is enabled only after that point, so host accesses cannot collide with the initial copy. The bank store contents are computed from a fixed formula and stand in for a non-volatile array.

Top module: `cfg_bank_loader`

## Requirements
- R1: While `rst_n` is low, `cfg_wr_en_o`, `load_done_o` and `host_bus_en_o` are 0.
- R2: The strap and both pins are captured on the first rising clock edge after `rst_n` goes high, and only there. Changes to them afterwards, up to the next reset, have no effect on the written data or on `host_bus_en_o`.
- R3: If the strap was 1, the bank index is `{pin_hi_i, pin_lo_i}` (00 gives bank 0, 01 gives bank 1, 10 gives bank 2, 11 gives bank 3), and `host_bus_en_o` stays 0.
- R4: If the strap was 0, bank 0 is loaded whatever the pins are, and `host_bus_en_o` is 1 once loading is done.
- R5: Writes start on the second rising edge after reset release. Each clock writes one register, with `cfg_wr_addr_o` running 0, 1, … NUM_REGS-1. The data for bank b, register i, is ((b*71) XOR (i*11) XOR 90) mod 2^DATA_W.
- R6: `load_done_o` rises on the edge after the last write, then stays 1 until reset, and no further write strobe is issued.
- R7: `host_bus_en_o` is 0 for as long as `load_done_o` is 0.
- R8: A reset asserted in the middle of a copy aborts it. After release, capture and copy start over from register 0, using the newly sampled strap and pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Mode strap; 1 selects hardware bank selection |
| pin_hi_i | input | 1 | Shared pin: bank select high bit or serial data line |
| pin_lo_i | input | 1 | Shared pin: bank select low bit or serial clock line |
| cfg_wr_en_o | output | 1 | Configuration register write strobe |
| cfg_wr_addr_o | output | ADDR_W | Configuration register index being written |
| cfg_wr_data_o | output | DATA_W | Data for the register being written |
| load_done_o | output | 1 | Sticky: the bank copy has finished |
| host_bus_en_o | output | 1 | Serial host register access enabled |

## Verification
The hardest condition to reach is one where the pins change after capture while the copy is still running. A design that samples late, or samples continuously, looks correct whenever the inputs are held steady. To expose it, the stimulus inverts the strap and both pins at every clock from the first edge after release onward. It then checks that every written word and the final bus-enable still match the values captured at the first edge. A second hard case is a reset that lands partway through a copy. The bench asserts reset mid-copy, confirms that the strobes stop at once, and then reloads a different bank from register 0.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_COPY = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    // Bank store content rule; callers truncate to their data width.
    function automatic int unsigned bank_word(input int unsigned bank, input int unsigned idx);
        return (bank * 71) ^ (idx * 11) ^ 90;
    endfunction

endpackage

// File: rtl/cbl_bank_rom.sv
module cbl_bank_rom #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 8,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 3
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] mem [NUM_BANKS][NUM_REGS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
            assign mem[b][i] = DATA_W'(cbl_pkg::bank_word(b, i));
        end
    end

    assign rd_data_o = mem[bank_i][addr_i];
endmodule

// File: rtl/cbl_strap_sampler.sv
module cbl_strap_sampler #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              pin_hi_i,
    input  logic              pin_lo_i,
    output logic              captured_o,
    output logic              host_mode_o,
    output logic [BANK_W-1:0] bank_o
);
    typedef struct packed {
        logic              captured;
        logic              host_mode;
        logic [BANK_W-1:0] bank;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.captured) begin
            s_d.captured  = 1'b1;
            s_d.host_mode = ~strap_i;
            s_d.bank      = strap_i ? BANK_W'({pin_hi_i, pin_lo_i}) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign captured_o  = s_q.captured;
    assign host_mode_o = s_q.host_mode;
    assign bank_o      = s_q.bank;
endmodule

// File: rtl/cbl_copy_seq.sv
module cbl_copy_seq
    import cbl_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              wr_en;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        unique case (q_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    q_d.st    = SEQ_COPY;
                    q_d.wr_en = 1'b1;
                    q_d.addr  = '0;
                end
            end
            SEQ_COPY: begin
                if (q_q.addr == LAST_IDX) begin
                    q_d.st    = SEQ_DONE;
                    q_d.wr_en = 1'b0;
                    q_d.done  = 1'b1;
                end else begin
                    q_d.addr  = q_q.addr + 1'b1;
                end
            end
            SEQ_DONE: begin
                q_d.wr_en = 1'b0;
                q_d.done  = 1'b1;
            end
            default: q_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign wr_en_o = q_q.wr_en;
    assign addr_o  = q_q.addr;
    assign done_o  = q_q.done;
endmodule

// File: rtl/cfg_bank_loader.sv
module cfg_bank_loader #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 2,
    parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              pin_hi_i,
    input  logic              pin_lo_i,
    output logic              cfg_wr_en_o,
    output logic [ADDR_W-1:0] cfg_wr_addr_o,
    output logic [DATA_W-1:0] cfg_wr_data_o,
    output logic              load_done_o,
    output logic              host_bus_en_o
);
    localparam int NUM_BANKS = 1 << BANK_W;

    logic              captured;
    logic              host_mode;
    logic [BANK_W-1:0] bank;
    logic              done;

    cbl_strap_sampler #(.BANK_W(BANK_W)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_i),
        .pin_hi_i    (pin_hi_i),
        .pin_lo_i    (pin_lo_i),
        .captured_o  (captured),
        .host_mode_o (host_mode),
        .bank_o      (bank)
    );

    cbl_copy_seq #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (captured),
        .wr_en_o (cfg_wr_en_o),
        .addr_o  (cfg_wr_addr_o),
        .done_o  (done)
    );

    cbl_bank_rom #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_REGS  (NUM_REGS),
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W)
    ) u_rom (
        .bank_i    (bank),
        .addr_i    (cfg_wr_addr_o),
        .rd_data_o (cfg_wr_data_o)
    );

    assign load_done_o   = done;
    assign host_bus_en_o = done & host_mode;
endmodule

// File: rtl/cfg_bank_loader_chk.sv
module cfg_bank_loader_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en_o,
    input logic [ADDR_W-1:0] cfg_wr_addr_o,
    input logic              load_done_o,
    input logic              host_bus_en_o
);
    // R7: the host bus opens only after loading
    p_bus_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_bus_en_o |-> load_done_o);

    // R6: no write strobe once done
    p_no_write_when_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |-> !cfg_wr_en_o);

    // R6: done is sticky
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |=> load_done_o);

    // R5: a copy begins at register 0
    p_first_addr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr_en_o) |-> cfg_wr_addr_o == '0);

    // R5: consecutive strobes step the address by one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en_o && $past(cfg_wr_en_o)) |-> cfg_wr_addr_o == $past(cfg_wr_addr_o) + 1'b1);

    // R2: bus enable does not move after loading completes
    p_bus_en_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done_o && $past(load_done_o)) |-> $stable(host_bus_en_o));
endmodule

bind cfg_bank_loader cfg_bank_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en_o   (cfg_wr_en_o),
    .cfg_wr_addr_o (cfg_wr_addr_o),
    .load_done_o   (load_done_o),
    .host_bus_en_o (host_bus_en_o)
);

// File: tb/cfg_bank_loader_test.sv
`timescale 1ns/1ps
module cfg_bank_loader_test;
    localparam int NUM_REGS = 8;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NVEC     = 7;

    // {strap, pin_hi, pin_lo, expected bank[1:0], expected bus enable}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b1_0_0_00_0, 6'b1_0_1_01_0, 6'b1_1_0_10_0, 6'b1_1_1_11_0,
        6'b0_0_0_00_1, 6'b0_1_1_00_1, 6'b0_0_1_00_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0, pin_hi = 1'b0, pin_lo = 1'b0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              done;
    logic              bus_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cfg_bank_loader #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_i       (strap),
        .pin_hi_i      (pin_hi),
        .pin_lo_i      (pin_lo),
        .cfg_wr_en_o   (wr_en),
        .cfg_wr_addr_o (wr_addr),
        .cfg_wr_data_o (wr_data),
        .load_done_o   (done),
        .host_bus_en_o (bus_en)
    );

    function automatic int exp_word(input int b, input int i);
        return ((b * 71) ^ (i * 11) ^ 90) & ((1 << DATA_W) - 1);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reset, release, then follow every cycle of one load.
    task automatic run_load(input logic st, input logic hi, input logic lo,
                            input int bank, input int bus, input bit wiggle);
        string mreq;
        mreq = st ? "R3" : "R4";
        @(negedge clk);
        rst_n = 1'b0; strap = st; pin_hi = hi; pin_lo = lo;
        @(negedge clk);
        check("R1", "wr_en in reset", int'(wr_en), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "bus_en in reset", int'(bus_en), 0);
        rst_n = 1'b1;
        for (int c = 1; c <= NUM_REGS + 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 1) begin
                check("R5", "no write on capture edge", int'(wr_en), 0);
                check("R7", "bus_en before done", int'(bus_en), 0);
            end else if (c <= NUM_REGS + 1) begin
                check("R5", "write strobe", int'(wr_en), 1);
                check("R5", "write address", int'(wr_addr), c - 2);
                check(mreq, "write data", int'(wr_data), exp_word(bank, c - 2));
                check("R6", "done during copy", int'(done), 0);
                check("R7", "bus_en during copy", int'(bus_en), 0);
            end else begin
                check("R6", "done after copy", int'(done), 1);
                check("R6", "no strobe after copy", int'(wr_en), 0);
                check(mreq, "bus_en after copy", int'(bus_en), bus);
            end
            if (wiggle) begin
                // R2: inputs change after capture and must be ignored
                strap = ~strap; pin_hi = ~pin_hi; pin_lo = ~pin_lo;
            end
        end
    endtask

    initial begin
        for (int v = 0; v < NVEC; v++) begin
            run_load(VEC[v][5], VEC[v][4], VEC[v][3], int'(VEC[v][2:1]), int'(VEC[v][0]), v >= 4);
        end

        // R2 with hardware selection and moving pins
        run_load(1'b1, 1'b0, 1'b1, 1, 0, 1'b1);

        // R6: done stays high, no strobes over a long idle stretch
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R6", "done still high", int'(done), 1);
        check("R6", "no late strobe", int'(wr_en), 0);

        // R8: reset in the middle of a copy, then reload another bank
        @(negedge clk);
        rst_n = 1'b0; strap = 1'b1; pin_hi = 1'b1; pin_lo = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8", "copy in progress", int'(wr_en), 1);
        check("R8", "mid-copy address", int'(wr_addr), 2);
        check("R8", "mid-copy data bank 3", int'(wr_data), exp_word(3, 2));
        rst_n = 1'b0;
        #1;
        check("R8", "strobe drops on reset", int'(wr_en), 0);
        check("R8", "done low on reset", int'(done), 0);
        run_load(1'b1, 1'b1, 1'b0, 2, 0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule